// File: doc/BRIEF.md
# Calibration Trigger Sequencer

This block decides when a converter's self-calibration runs. It works in the input-clock domain. After reset, and again after every exit from power-down, it waits a fixed number of cycles and then starts one automatic calibration. The wait is short or long, chosen by a select input. When the extended serial-control mode is active the select is overridden and the short wait is always used.

Outside the automatic run, software or a board pin can ask for a calibration by holding the request input low and then high. Each level must last at least a qualifying number of cycles. While a calibration is in progress the block raises a running flag. It sends a one-cycle start pulse and a one-cycle done pulse to a calibration engine stub, and it times the run with an internal counter of fixed length. A high level on the power-down input aborts any run and holds the block inactive.

Top module: `cal_trig_seq`

## Requirements
- R1: While rst_ni is low and on the first sample after reset is released, cal_run_o, cal_start_o and cal_done_o are all low.
- R2: With dly_sel_i=0, cal_run_o first rises SHORT_DLY clock cycles after reset is released.
- R3: With dly_sel_i=1 and ext_ctl_i=0, cal_run_o first rises LONG_DLY clock cycles after reset is released.
- R4: With ext_ctl_i=1, the power-up delay is SHORT_DLY cycles whatever value dly_sel_i has.
- R5: cal_run_o stays high for exactly CAL_CYCLES consecutive cycles. cal_start_o is high only in the first of those cycles. cal_done_o is high only in the first cycle after cal_run_o falls at the end of a completed run.
- R6: From idle, a command calibration starts when cal_req_i has been sampled low on at least QUAL_CYCLES consecutive cycles and then high on QUAL_CYCLES consecutive cycles. cal_run_o rises in the cycle after the last qualifying high sample.
- R7: A low phase shorter than QUAL_CYCLES, followed by any length of high, starts no calibration.
- R8: A high phase shorter than QUAL_CYCLES clears the qualification. A full low phase must be seen again before a high phase can qualify.
- R9: Request activity during a run is ignored, and qualification restarts from zero when the run ends. Low cycles sampled during a run do not count toward a later command.
- R10: A high pwr_dn_i drops cal_run_o on the next cycle without a done pulse. No calibration runs while pwr_dn_i stays high. After pwr_dn_i falls, the automatic calibration starts again after the power-up delay plus one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_req_i | input | 1 | Calibration request level (low then high) |
| pwr_dn_i | input | 1 | Power-down, active high |
| dly_sel_i | input | 1 | Power-up delay select: 0 short, 1 long |
| ext_ctl_i | input | 1 | Extended serial-control mode active; forces short delay |
| cal_run_o | output | 1 | Calibration in progress |
| cal_start_o | output | 1 | One-cycle start strobe to calibration engine |
| cal_done_o | output | 1 | One-cycle completion strobe |

## Verification
A wrong sequencer state shows up at cal_run_o. A stuck or misloaded delay or run counter moves the edges of cal_run_o by whole cycles, so the bench counts cycles exactly and rejects an edge that is one cycle early or late. A qualifier that keeps stale counts fires a calibration after a short, split or mid-run request pattern. That shows as cal_run_o rising within one cycle of the offending high sample, and the bench watches cal_run_o through each such window. A missed power-down transition shows as cal_run_o still high, or a done pulse, on the sample right after pwr_dn_i rises.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  typedef enum logic [1:0] {
    ST_PWRDN = 2'd0,
    ST_WAIT  = 2'd1,
    ST_IDLE  = 2'd2,
    ST_RUN   = 2'd3
  } cal_state_e;
endpackage

// File: rtl/cal_req_qual.sv
module cal_req_qual #(
  parameter int QUAL_CYCLES = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic req_i,
  output logic fire_o
);
  localparam int W = $clog2(QUAL_CYCLES + 1);
  localparam logic [W-1:0] QMAX  = W'(QUAL_CYCLES);
  localparam logic [W-1:0] QLAST = W'(QUAL_CYCLES - 1);
  localparam logic [W-1:0] ONE   = W'(1);

  logic [W-1:0] low_q, high_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= '0;
      high_q <= '0;
    end else if (!en_i) begin
      low_q  <= '0;
      high_q <= '0;
    end else if (req_i) begin
      if (low_q != QMAX) low_q <= '0;          // high without full low phase
      else if (high_q != QMAX) high_q <= high_q + ONE;
    end else begin
      high_q <= '0;
      if (high_q != '0) low_q <= ONE;          // short high: low phase restarts
      else if (low_q != QMAX) low_q <= low_q + ONE;
    end
  end

  assign fire_o = en_i && req_i && (low_q == QMAX) && (high_q == QLAST);

  assert_high_needs_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (high_q != '0) |-> (low_q == QMAX));

  assert_disabled_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (low_q == '0 && high_q == '0));
endmodule

// File: rtl/cal_delay_timer.sv
module cal_delay_timer #(
  parameter int SHORT_DLY = 1024,
  parameter int LONG_DLY  = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic long_i,
  output logic expire_o
);
  localparam int MAXD = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
  localparam int W = $clog2(MAXD + 1);
  localparam logic [W-1:0] SHORT_LAST = W'(SHORT_DLY - 1);
  localparam logic [W-1:0] LONG_LAST  = W'(LONG_DLY - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] lim;

  assign lim      = long_i ? LONG_LAST : SHORT_LAST;
  assign expire_o = en_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!en_i)        cnt_q <= '0;
    else if (!expire_o)    cnt_q <= cnt_q + W'(1);
  end

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= LONG_LAST || cnt_q <= SHORT_LAST));
endmodule

// File: rtl/cal_run_timer.sv
module cal_run_timer #(
  parameter int CAL_CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic expire_o
);
  localparam int W = $clog2(CAL_CYCLES + 1);
  localparam logic [W-1:0] LAST = W'(CAL_CYCLES - 1);

  logic [W-1:0] cnt_q;

  assign expire_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!en_i)     cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + W'(1);
  end

  assert_run_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/cal_trig_seq.sv
module cal_trig_seq
  import cal_seq_pkg::*;
#(
  parameter int QUAL_CYCLES = 80,
  parameter int SHORT_DLY   = 1024,
  parameter int LONG_DLY    = 65536,
  parameter int CAL_CYCLES  = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cal_req_i,
  input  logic pwr_dn_i,
  input  logic dly_sel_i,
  input  logic ext_ctl_i,
  output logic cal_run_o,
  output logic cal_start_o,
  output logic cal_done_o
);
  cal_state_e state_q, state_d;
  logic dly_exp, run_exp, cmd_fire;
  logic start_q, done_q;

  cal_delay_timer #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) i_dly (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (state_q == ST_WAIT),
    .long_i   (dly_sel_i && !ext_ctl_i),
    .expire_o (dly_exp)
  );

  cal_run_timer #(.CAL_CYCLES(CAL_CYCLES)) i_run (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (state_q == ST_RUN),
    .expire_o (run_exp)
  );

  cal_req_qual #(.QUAL_CYCLES(QUAL_CYCLES)) i_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_IDLE),
    .req_i  (cal_req_i),
    .fire_o (cmd_fire)
  );

  always_comb begin
    state_d = state_q;
    if (pwr_dn_i) state_d = ST_PWRDN;
    else begin
      unique case (state_q)
        ST_PWRDN: state_d = ST_WAIT;
        ST_WAIT:  if (dly_exp)  state_d = ST_RUN;
        ST_IDLE:  if (cmd_fire) state_d = ST_RUN;
        ST_RUN:   if (run_exp)  state_d = ST_IDLE;
        default:  state_d = ST_PWRDN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= (state_q != ST_RUN) && (state_d == ST_RUN);
      done_q  <= (state_q == ST_RUN) && (state_d == ST_IDLE);
    end
  end

  assign cal_run_o   = (state_q == ST_RUN);
  assign cal_start_o = start_q;
  assign cal_done_o  = done_q;

  assert_start_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_o |-> (cal_run_o && !$past(cal_run_o)));

  assert_done_after_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_done_o |-> (!cal_run_o && $past(cal_run_o)));

  assert_rise_has_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cal_run_o) |-> cal_start_o);

  assert_pd_stops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |=> (!cal_run_o && !cal_done_o && !cal_start_o));

  assert_cmd_on_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && $past(state_q) == ST_IDLE) |-> $past(cal_req_i));
endmodule

// File: tb/test_cal_trig_seq.sv
module test_cal_trig_seq;
  localparam int QUAL  = 80;
  localparam int SHORT = 32;
  localparam int LONG  = 200;
  localparam int CAL   = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b1, pd = 1'b0, dsel = 1'b0, ext = 1'b0;
  logic run, start, done;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cal_trig_seq #(.QUAL_CYCLES(QUAL), .SHORT_DLY(SHORT), .LONG_DLY(LONG),
                 .CAL_CYCLES(CAL)) i_cal_trig_seq (
    .clk_i(clk), .rst_ni(rst_n), .cal_req_i(req), .pwr_dn_i(pd),
    .dly_sel_i(dsel), .ext_ctl_i(ext),
    .cal_run_o(run), .cal_start_o(start), .cal_done_o(done));

  task automatic chk(input bit ok, input string rq, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp_v);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // negedges from now until run seen high (limit -> returns limit+1)
  task automatic wait_run(input int limit, output int n);
    n = 0;
    while (n <= limit) begin
      @(negedge clk); n++;
      if (run) return;
    end
  endtask

  // with run just seen high: measure run length and pulses
  task automatic check_run(input string rq);
    int len = 1;
    int starts = start ? 1 : 0;
    while (1) begin
      @(negedge clk);
      if (!run) break;
      len++;
      if (start) starts++;
      if (len > CAL + 5) break;
    end
    chk(len == CAL, rq, len, CAL);
    chk(starts == 1, rq, starts, 1);
    chk(done == 1'b1, rq, done, 1);
    @(negedge clk);
    chk(done == 1'b0, rq, done, 0);
  endtask

  task automatic watch_no_run(input int cyc, input string rq);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (run) seen++;
    end
    chk(seen == 0, rq, seen, 0);
  endtask

  task automatic idle_prep();
    int n;
    req = 1'b1; dsel = 1'b0; ext = 1'b0; pd = 1'b0;
    do_reset();
    wait_run(SHORT + 5, n);
    while (run) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!run && !start && !done, "R1", {run, start, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!run && !start && !done, "R1", {run, start, done}, 0);
  endtask

  task automatic t_short();
    int n;
    dsel = 1'b0; ext = 1'b0;
    do_reset();
    wait_run(LONG + 10, n);
    chk(n == SHORT, "R2", n, SHORT);
    chk(start == 1'b1, "R5", start, 1);
    check_run("R5");
  endtask

  task automatic t_long();
    int n;
    dsel = 1'b1; ext = 1'b0;
    do_reset();
    wait_run(LONG + 10, n);
    chk(n == LONG, "R3", n, LONG);
    check_run("R5");
  endtask

  task automatic t_ext();
    int n;
    dsel = 1'b1; ext = 1'b1;
    do_reset();
    wait_run(LONG + 10, n);
    chk(n == SHORT, "R4", n, SHORT);
    check_run("R5");
    dsel = 1'b0; ext = 1'b0;
  endtask

  task automatic drive_lvl(input logic v, input int cyc);
    req = v;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic t_cmd();
    idle_prep();
    drive_lvl(1'b0, QUAL);
    req = 1'b1;
    for (int i = 1; i <= QUAL; i++) begin
      @(negedge clk);
      if (i == QUAL - 1) chk(run == 1'b0, "R6", run, 0);
    end
    chk(run == 1'b1, "R6", run, 1);
    chk(start == 1'b1, "R6", start, 1);
    check_run("R6");
  endtask

  task automatic t_short_low();
    idle_prep();
    drive_lvl(1'b0, QUAL - 1);
    req = 1'b1;
    watch_no_run(QUAL + 20, "R7");
  endtask

  task automatic t_short_high();
    int n;
    idle_prep();
    drive_lvl(1'b0, QUAL);
    drive_lvl(1'b1, QUAL / 2);
    drive_lvl(1'b0, 10);
    req = 1'b1;
    watch_no_run(QUAL + 20, "R8");
    drive_lvl(1'b0, QUAL);
    req = 1'b1;
    wait_run(QUAL + 10, n);
    chk(n == QUAL, "R8", n, QUAL);
    check_run("R8");
  endtask

  task automatic t_busy();
    int n;
    idle_prep();
    drive_lvl(1'b0, QUAL);
    req = 1'b1;
    wait_run(QUAL + 10, n);
    chk(n == QUAL, "R9", n, QUAL);
    req = 1'b0;                      // low through the whole run
    while (run) @(negedge clk);
    req = 1'b1;
    watch_no_run(QUAL + 20, "R9");
  endtask

  task automatic t_pd();
    int n;
    idle_prep();
    drive_lvl(1'b0, QUAL);
    req = 1'b1;
    wait_run(QUAL + 10, n);
    repeat (5) @(negedge clk);
    pd = 1'b1;
    @(negedge clk);
    chk(run == 1'b0, "R10", run, 0);
    chk(done == 1'b0, "R10", done, 0);
    drive_lvl(1'b0, QUAL);
    req = 1'b1;
    watch_no_run(QUAL + SHORT + 20, "R10");
    pd = 1'b0;
    wait_run(LONG + 10, n);
    chk(n == SHORT + 1, "R10", n, SHORT + 1);
    check_run("R10");
  endtask

  initial begin
    t_reset();
    t_short();
    t_long();
    t_ext();
    t_cmd();
    t_short_low();
    t_short_high();
    t_busy();
    t_pd();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule